// File: doc/BRIEF.md
# Majority-Voting Replicated Memory

This block is a word-addressed memory that keeps several identical copies of every stored word, so that a transient upset in one copy never reaches the requester. A write places the same word into every replica. A read fetches all replicas at once, forms a per-bit majority and returns that voted word. It also raises a flag when any copy disagreed with the vote.

Requests use a single-outstanding valid/ready handshake. The block reports completion with a one-cycle `done` pulse, and a requester must wait for that pulse instead of counting cycles. Reads that find a disagreement can optionally repair the storage. In that case the voted word is written back into every replica, and the read takes one extra cycle. A dedicated upset port lets a test environment overwrite one replica's word, which models a bit flip in a single copy.

Top module: `replica_vote_mem`

## Requirements
- R1: A write stores `req_wdata` at `req_addr` in every replica, and a later read of that address returns the same word.
- R2: When one replica holds a corrupted word, a read still returns the written word and `mismatch` is 1 with `done`.
- R3: `mismatch` is 0 with `done` for every write and for every read whose replicas all agree, and it is 0 whenever `done` is 0.
- R4: A request is taken only on a rising clock edge where `req_valid` and `ready` are both 1. `ready` is 0 from the cycle after acceptance until `done` has been shown, and a request presented while `ready` is 0 has no effect.
- R5: `done` is high for exactly one cycle per request, `ready` is 0 while `done` is high, and `ready` is 1 in the cycle after `done`.
- R6: Latency from the accepting edge to `done`: 1 cycle for a write (`req_op`=1), 2 cycles for a read (`req_op`=0) whose replicas agree.
- R7: With write-back enabled (the default), a read that finds a disagreement takes 3 cycles. It rewrites the voted word into every replica, so the next read of that address has `mismatch`=0.
- R8: `upset_we` overwrites only the replica selected by `upset_sel` (0 to REPLICAS-1) at `upset_addr` with `upset_data`. It acts only when `ready` is 1 and `req_valid` is 0, and it is ignored otherwise.
- R9: After reset, `ready` is 1, `done` is 0 and `mismatch` is 0.
- R10: The vote is per bit. Corruptions in different bits of different replicas are all outvoted, and the read returns the written word with `mismatch`=1.
- R11: A bit that a majority of replicas hold flipped is returned flipped, because the vote follows the majority per bit even when that majority is wrong.
- R12: `req_wdata` has no effect on a read request, and the stored word is unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data, used only for writes |
| ready | output | 1 | Block idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Voted read word, valid with `done` after a read |
| mismatch | output | 1 | Some replica differed from the vote, valid with `done` |
| upset_we | input | 1 | Overwrite one replica word (fault model) |
| upset_sel | input | SEL_W | Replica index to overwrite |
| upset_addr | input | ADDR_W | Address to overwrite |
| upset_data | input | DATA_W | Word placed in the chosen replica |

## Verification
The assertions cover the handshake on every cycle. They check that `ready` and `done` never overlap and that `done` lasts one cycle and is followed by `ready`. They also check that an accepted write completes on the next cycle with no mismatch, that a read never completes on the next cycle, and that `mismatch` is never seen without `done`. Only the bench scenarios can show what happens to the data. Those scenarios cover the voted results under single and double corruptions in the same or different bits, the repair done by write-back, and the extra cycle it costs. They also cover the cases where upset writes and request data must be ignored.

// File: rtl/rvm_pkg.sv
package rvm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VOTE = 2'd1,
    ST_FIX  = 2'd2,
    ST_RESP = 2'd3
  } rvm_state_t;

  localparam logic OP_READ  = 1'b0;
  localparam logic OP_WRITE = 1'b1;

endpackage

// File: rtl/rvm_replica_ram.sv
module rvm_replica_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  // single-port synchronous RAM, read-first
  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end

endmodule

// File: rtl/rvm_voter.sv
module rvm_voter #(
  parameter int REPLICAS = 3,
  parameter int DATA_W   = 16,
  localparam int CNT_W   = $clog2(REPLICAS + 1),
  localparam int HALF    = REPLICAS / 2
) (
  input  logic [REPLICAS*DATA_W-1:0] words,
  output logic [DATA_W-1:0]          voted,
  output logic                       disagree
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic [CNT_W-1:0] ones;
    always_comb begin
      ones = '0;
      for (int r = 0; r < REPLICAS; r++) begin
        ones = ones + CNT_W'(words[r*DATA_W + b]);
      end
    end
    assign voted[b] = (ones > CNT_W'(HALF));
  end

  always_comb begin
    disagree = 1'b0;
    for (int r = 0; r < REPLICAS; r++) begin
      if (words[r*DATA_W +: DATA_W] != voted) disagree = 1'b1;
    end
  end

endmodule

// File: rtl/rvm_ctrl.sv
module rvm_ctrl
  import rvm_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int REPLICAS  = 3,
  parameter bit WRITEBACK = 1'b1,
  localparam int SEL_W    = $clog2(REPLICAS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                upset_we,
  input  logic [SEL_W-1:0]    upset_sel,
  input  logic [ADDR_W-1:0]   upset_addr,
  input  logic [DATA_W-1:0]   upset_data,
  input  logic [DATA_W-1:0]   voted,
  input  logic                disagree,
  output logic [REPLICAS-1:0] ram_we,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic [DATA_W-1:0]   ram_wdata,
  output logic                ready,
  output logic                done,
  output logic [DATA_W-1:0]   rdata,
  output logic                mismatch
);

  rvm_state_t        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] word_q;
  logic              mism_q;

  logic idle, accept, wr_acc, upset_ok, fixing;

  assign idle     = (st_q == ST_IDLE);
  assign accept   = idle && req_valid;
  assign wr_acc   = accept && (req_op == OP_WRITE);
  assign upset_ok = idle && !req_valid && upset_we;
  assign fixing   = (st_q == ST_FIX);

  // shared RAM port: requests win over upsets, repairs use latched address
  always_comb begin
    if (idle) begin
      ram_addr  = req_valid ? req_addr  : upset_addr;
      ram_wdata = req_valid ? req_wdata : upset_data;
    end else begin
      ram_addr  = addr_q;
      ram_wdata = word_q;
    end
  end

  for (genvar r = 0; r < REPLICAS; r++) begin : g_we
    assign ram_we[r] = wr_acc || fixing ||
                       (upset_ok && (upset_sel == SEL_W'(r)));
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = (req_op == OP_WRITE) ? ST_RESP : ST_VOTE;
      ST_VOTE: st_d = (WRITEBACK && disagree) ? ST_FIX : ST_RESP;
      ST_FIX:  st_d = ST_RESP;
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      word_q <= '0;
      mism_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) addr_q <= req_addr;
      if (wr_acc) mism_q <= 1'b0;
      if (st_q == ST_VOTE) begin
        word_q <= voted;
        mism_q <= disagree;
      end
    end
  end

  assign ready    = idle;
  assign done     = (st_q == ST_RESP);
  assign rdata    = word_q;
  assign mismatch = mism_q && (st_q == ST_RESP);

endmodule

// File: rtl/replica_vote_mem.sv
module replica_vote_mem #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int REPLICAS  = 3,
  parameter bit WRITEBACK = 1'b1,
  localparam int SEL_W    = $clog2(REPLICAS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mismatch,
  input  logic              upset_we,
  input  logic [SEL_W-1:0]  upset_sel,
  input  logic [ADDR_W-1:0] upset_addr,
  input  logic [DATA_W-1:0] upset_data
);

  logic [REPLICAS-1:0]        ram_we;
  logic [ADDR_W-1:0]          ram_addr;
  logic [DATA_W-1:0]          ram_wdata;
  logic [REPLICAS*DATA_W-1:0] ram_words;
  logic [DATA_W-1:0]          voted;
  logic                       disagree;

  for (genvar r = 0; r < REPLICAS; r++) begin : g_rep
    rvm_replica_ram #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
    ) u_ram (
      .clk  (clk),
      .we   (ram_we[r]),
      .addr (ram_addr),
      .wdata(ram_wdata),
      .rdata(ram_words[r*DATA_W +: DATA_W])
    );
  end

  rvm_voter #(
    .REPLICAS(REPLICAS),
    .DATA_W  (DATA_W)
  ) u_vote (
    .words   (ram_words),
    .voted   (voted),
    .disagree(disagree)
  );

  rvm_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REPLICAS (REPLICAS),
    .WRITEBACK(WRITEBACK)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .upset_we  (upset_we),
    .upset_sel (upset_sel),
    .upset_addr(upset_addr),
    .upset_data(upset_data),
    .voted     (voted),
    .disagree  (disagree),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ready     (ready),
    .done      (done),
    .rdata     (rdata),
    .mismatch  (mismatch)
  );

endmodule

// File: rtl/replica_vote_mem_checker.sv
module replica_vote_mem_checker (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_op,
  input logic ready,
  input logic done,
  input logic mismatch
);

  // R5: completion and idle never coincide
  p_ready_done_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(ready && done));

  // R5: done is a single-cycle pulse followed by ready
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && ready));

  // R4: an accepted request drops ready on the next cycle
  p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready) |=> !ready);

  // R6 / R3: write completes next cycle without mismatch
  p_write_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready && req_op) |=> (done && !mismatch));

  // R6: a read never completes in one cycle
  p_read_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ready && !req_op) |=> !done);

  // R3: mismatch only accompanies done
  p_mismatch_qualified_r3: assert property (@(posedge clk) disable iff (rst)
    mismatch |-> done);

endmodule

bind replica_vote_mem replica_vote_mem_checker u_checker (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_op   (req_op),
  .ready    (ready),
  .done     (done),
  .mismatch (mismatch)
);

// File: tb/replica_vote_mem_test.sv
module replica_vote_mem_test;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NR = 3;
  localparam int SW = $clog2(NR);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_op = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          ready, done, mismatch;
  logic [DW-1:0] rdata;
  logic          upset_we = 1'b0;
  logic [SW-1:0] upset_sel = '0;
  logic [AW-1:0] upset_addr = '0;
  logic [DW-1:0] upset_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  replica_vote_mem uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .done(done), .rdata(rdata), .mismatch(mismatch),
    .upset_we(upset_we), .upset_sel(upset_sel), .upset_addr(upset_addr), .upset_data(upset_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] q, output logic mm, output int lat);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_op = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    q = rdata;
    mm = mismatch;
  endtask

  task automatic upset(input int sel, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    upset_we = 1'b1; upset_sel = SW'(sel); upset_addr = a; upset_data = d;
    @(negedge clk);
    upset_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 ready", 32'(ready), 1);
    chk("R9 done", 32'(done), 0);
    chk("R9 mismatch", 32'(mismatch), 0);
  endtask

  task automatic t_clean;
    logic [DW-1:0] q; logic mm; int lat;
    logic [DW-1:0] pats [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h1234};
    for (int i = 0; i < 4; i++) begin
      do_req(1'b1, AW'(i * 7), pats[i], q, mm, lat);
      chk("R6 write latency", 32'(lat), 1);
      chk("R3 write mismatch", 32'(mm), 0);
    end
    for (int i = 0; i < 4; i++) begin
      do_req(1'b0, AW'(i * 7), 16'h0, q, mm, lat);
      chk("R1 read data", 32'(q), 32'(pats[i]));
      chk("R3 clean mismatch", 32'(mm), 0);
      chk("R6 read latency", 32'(lat), 2);
    end
  endtask

  task automatic t_single_flip;
    logic [DW-1:0] q; logic mm; int lat;
    for (int r = 0; r < NR; r++) begin
      logic [DW-1:0] d = 16'h3C00 + DW'(r);
      do_req(1'b1, 6'd40, d, q, mm, lat);
      upset(r, 6'd40, d ^ (16'h1 << (r + 4)));
      do_req(1'b0, 6'd40, 16'h0, q, mm, lat);
      chk("R2 voted data", 32'(q), 32'(d));
      chk("R2 mismatch flag", 32'(mm), 1);
      chk("R7 repair latency", 32'(lat), 3);
      do_req(1'b0, 6'd40, 16'h0, q, mm, lat);
      chk("R7 repaired mismatch", 32'(mm), 0);
      chk("R7 repaired data", 32'(q), 32'(d));
    end
  endtask

  task automatic t_diff_bits;
    logic [DW-1:0] q; logic mm; int lat;
    do_req(1'b1, 6'd50, 16'h8001, q, mm, lat);
    upset(0, 6'd50, 16'h8001 ^ 16'h0001);
    upset(1, 6'd50, 16'h8001 ^ 16'h0002);
    upset(2, 6'd50, 16'h8001 ^ 16'h8000);
    do_req(1'b0, 6'd50, 16'h0, q, mm, lat);
    chk("R10 per-bit vote", 32'(q), 32'h8001);
    chk("R10 mismatch", 32'(mm), 1);
  endtask

  task automatic t_same_bit;
    logic [DW-1:0] q; logic mm; int lat;
    do_req(1'b1, 6'd51, 16'h0F0F, q, mm, lat);
    upset(0, 6'd51, 16'h0F0F ^ 16'h0008);
    upset(2, 6'd51, 16'h0F0F ^ 16'h0008);
    do_req(1'b0, 6'd51, 16'h0, q, mm, lat);
    chk("R11 majority wins", 32'(q), 32'h0F07);
    chk("R11 mismatch", 32'(mm), 1);
    do_req(1'b0, 6'd51, 16'h0, q, mm, lat);
    chk("R11 settled value", 32'(q), 32'h0F07);
    chk("R7 settled mismatch", 32'(mm), 0);
  endtask

  task automatic t_upset_ignored;
    logic [DW-1:0] q; logic mm; int lat;
    do_req(1'b1, 6'd60, 16'hBEEF, q, mm, lat);
    // upset during the done cycle (ready low)
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_op = 1'b1; req_addr = 6'd61; req_wdata = 16'h7777;
    @(negedge clk);
    req_valid = 1'b0;
    upset_we = 1'b1; upset_sel = 0; upset_addr = 6'd60; upset_data = 16'h0000;
    chk("R8 busy ready", 32'(ready), 0);
    @(negedge clk);
    upset_we = 1'b0;
    // upset alongside a request in the idle state
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_op = 1'b0; req_addr = 6'd61; req_wdata = 16'h0;
    upset_we = 1'b1; upset_sel = 1; upset_addr = 6'd60; upset_data = 16'h0000;
    @(negedge clk);
    req_valid = 1'b0; upset_we = 1'b0;
    while (!done) @(negedge clk);
    do_req(1'b0, 6'd60, 16'h0, q, mm, lat);
    chk("R8 upset ignored data", 32'(q), 32'hBEEF);
    chk("R8 upset ignored mismatch", 32'(mm), 0);
  endtask

  task automatic t_wdata_on_read;
    logic [DW-1:0] q; logic mm; int lat;
    do_req(1'b1, 6'd20, 16'h5A5A, q, mm, lat);
    do_req(1'b0, 6'd20, 16'hFFFF, q, mm, lat);
    chk("R12 read data", 32'(q), 32'h5A5A);
    do_req(1'b0, 6'd20, 16'h0000, q, mm, lat);
    chk("R12 storage unchanged", 32'(q), 32'h5A5A);
    chk("R12 mismatch", 32'(mm), 0);
  endtask

  task automatic t_handshake;
    logic [DW-1:0] q; logic mm; int lat;
    do_req(1'b1, 6'd30, 16'h1111, q, mm, lat);
    chk("R5 ready during done", 32'(ready), 0);
    req_valid = 1'b1; req_op = 1'b1; req_addr = 6'd30; req_wdata = 16'hDEAD;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 ready after done", 32'(ready), 1);
    chk("R5 done single pulse", 32'(done), 0);
    do_req(1'b0, 6'd30, 16'h0, q, mm, lat);
    chk("R4 busy request ignored", 32'(q), 32'h1111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single_flip();
    t_diff_bits();
    t_same_bit();
    t_upset_ignored();
    t_wdata_on_read();
    t_handshake();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule